// File: doc/BRIEF.md
# Hardware Context Scheduler

This block keeps the lifecycle of a fixed pool of execution-context slots and a first-in first-out queue of the slots that are waiting to run. Each cycle the decode stage may hand it one command. The commands are yield, halt, free, new, resume, state query and ready count. The block tracks which slot owns the core and reports it on `run_id`. When no slot can be dispatched, it raises `idle`.

The new, state query and ready count commands return a value on `res_data`, flagged by `res_valid`, in the cycle after the command. A privileged clear input returns the whole pool to the unallocated state.

Register save and restore, the preemption timer and instruction decode all sit outside this block. A timer expiry is issued to it as a yield.

Top module: `ctx_sched`

## Requirements
- R1: After reset, slot 0 owns the core: `run_id` is 0, `idle` is 0 and `res_valid` is 0. Every other slot is free and the queue is empty.
- R2: Slot states are encoded as 00 free, 01 running, 10 ready and 11 halted. The state query (cmd 6) returns the code of slot `cmd_arg`, zero-extended, on `res_data` with `res_valid` high in the next cycle. If `cmd_arg` is not below the slot count, the query returns all ones.
- R3: New (cmd 4) takes the lowest-numbered free slot, marks it ready, appends it to the queue and returns its number in the next cycle. When no slot is free it returns all ones and changes nothing.
- R4: Yield (cmd 1) appends the running slot to the tail of the queue as ready, then dispatches the head. If the queue was empty, the same slot keeps running.
- R5: Halt (cmd 2) marks the running slot halted without queuing it. The head of the queue is dispatched, or `idle` is raised when the queue is empty.
- R6: Free (cmd 3) marks the running slot free and then dispatches exactly as halt does.
- R7: Resume (cmd 5) on a halted slot marks it ready and appends it to the queue. On a slot in any other state, or on an out-of-range number, it has no effect.
- R8: Ready count (cmd 7) returns the number of queued slots in the next cycle.
- R9: While `idle` is high, yield, halt and free are ignored. When the queue is non-empty during idle, its head is dispatched at the next edge and `idle` falls.
- R10: `pool_clr` frees every slot, empties the queue and raises `idle` at the next edge. It overrides any command given in the same cycle.
- R11: Slots are dispatched in the order they entered the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code: 0 none, 1 yield, 2 halt, 3 free, 4 new, 5 resume, 6 state query, 7 ready count |
| cmd_arg | input | RES_W | Slot number for resume and state query |
| pool_clr | input | 1 | Privileged clear of the whole pool |
| run_id | output | ID_W | Slot that owns the core |
| idle | output | 1 | No slot owns the core |
| res_valid | output | 1 | `res_data` holds a result |
| res_data | output | RES_W | Result of new, state query or ready count |

## Verification
The bench builds the block with six slots and an 8-bit argument and result, so it reaches conditions that the default 32-slot pool would rarely hit. In random traffic the pool runs out often, which exercises the all-ones result of new. The queue depth is not a power of two, so its pointers wrap at an irregular depth. Argument values from 6 to 9 exercise the out-of-range paths of resume and state query.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
  typedef enum logic [1:0] {
    ST_FREE  = 2'b00,
    ST_RUN   = 2'b01,
    ST_READY = 2'b10,
    ST_HALT  = 2'b11
  } slot_st_e;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_YIELD  = 3'd1,
    OP_HALT   = 3'd2,
    OP_FREE   = 3'd3,
    OP_NEW    = 3'd4,
    OP_RESUME = 3'd5,
    OP_STATE  = 3'd6,
    OP_COUNT  = 3'd7
  } sched_op_e;
endpackage

// File: rtl/ctx_id_fifo.sv
module ctx_id_fifo #(
  parameter int DEPTH = 32,
  parameter int ID_W  = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [ID_W-1:0]  push_id,
  input  logic             pop,
  output logic [ID_W-1:0]  head_id,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = bump(wr_q);
      if (pop)  rd_d = bump(rd_q);
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  assign cnt_en = clr || push || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem_q[wr_q] <= push_id;
  end

  assign head_id = mem_q[rd_q];
  assign count   = cnt_q;
  assign empty   = (cnt_q == '0);

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> (cnt_q < CNT_W'(DEPTH)));
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> (cnt_q != '0));
endmodule

// File: rtl/ctx_free_finder.sv
module ctx_free_finder #(
  parameter int N    = 32,
  parameter int ID_W = 5
) (
  input  logic [N-1:0]    free_vec,
  output logic            found,
  output logic [ID_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        found = 1'b1;
        idx   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
  import ctx_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int RES_W     = 8,
  localparam int ID_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd,
  input  logic [RES_W-1:0] cmd_arg,
  input  logic             pool_clr,
  output logic [ID_W-1:0]  run_id,
  output logic             idle,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  sched_op_e        op;
  slot_st_e         st_q [NUM_SLOTS];
  slot_st_e         st_d [NUM_SLOTS];
  logic [ID_W-1:0]  run_q, run_d;
  logic             idle_q, idle_d;
  logic             resv_q, resv_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [NUM_SLOTS-1:0] free_vec;
  logic             free_found;
  logic [ID_W-1:0]  free_idx;
  logic             push, pop;
  logic [ID_W-1:0]  push_id, q_head;
  logic [CNT_W-1:0] q_count;
  logic             q_empty;
  logic             arg_ok;
  logic [ID_W-1:0]  arg_id;
  slot_st_e         arg_st;
  logic             tbl_en;

  assign op     = sched_op_e'(cmd);
  assign arg_ok = (cmd_arg < RES_W'(NUM_SLOTS));
  assign arg_id = cmd_arg[ID_W-1:0];
  assign arg_st = arg_ok ? st_q[arg_id] : ST_FREE;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_free
    assign free_vec[g] = (st_q[g] == ST_FREE);
  end

  ctx_free_finder #(.N(NUM_SLOTS), .ID_W(ID_W)) u_find (
    .free_vec (free_vec),
    .found    (free_found),
    .idx      (free_idx)
  );

  ctx_id_fifo #(.DEPTH(NUM_SLOTS), .ID_W(ID_W)) u_rdyq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pool_clr),
    .push    (push),
    .push_id (push_id),
    .pop     (pop),
    .head_id (q_head),
    .count   (q_count),
    .empty   (q_empty)
  );

  // Next-state: dispatch first, then the pool commands that enqueue.
  always_comb begin
    st_d    = st_q;
    run_d   = run_q;
    idle_d  = idle_q;
    push    = 1'b0;
    push_id = '0;
    pop     = 1'b0;
    res_d   = '0;
    resv_d  = 1'b0;
    if (pool_clr) begin
      for (int i = 0; i < NUM_SLOTS; i++) st_d[i] = ST_FREE;
      idle_d = 1'b1;
    end else begin
      if (!idle_q) begin
        case (op)
          OP_YIELD: begin
            if (!q_empty) begin
              push          = 1'b1;
              push_id       = run_q;
              pop           = 1'b1;
              st_d[run_q]   = ST_READY;
              st_d[q_head]  = ST_RUN;
              run_d         = q_head;
            end
          end
          OP_HALT, OP_FREE: begin
            st_d[run_q] = (op == OP_HALT) ? ST_HALT : ST_FREE;
            if (!q_empty) begin
              pop          = 1'b1;
              st_d[q_head] = ST_RUN;
              run_d        = q_head;
            end else begin
              idle_d = 1'b1;
            end
          end
          default: ;
        endcase
      end else if (!q_empty) begin
        pop          = 1'b1;
        st_d[q_head] = ST_RUN;
        run_d        = q_head;
        idle_d       = 1'b0;
      end

      case (op)
        OP_NEW: begin
          resv_d = 1'b1;
          if (free_found) begin
            st_d[free_idx] = ST_READY;
            push           = 1'b1;
            push_id        = free_idx;
            res_d          = RES_W'(free_idx);
          end else begin
            res_d = '1;
          end
        end
        OP_RESUME: begin
          if (arg_ok && arg_st == ST_HALT) begin
            st_d[arg_id] = ST_READY;
            push         = 1'b1;
            push_id      = arg_id;
          end
        end
        OP_STATE: begin
          resv_d = 1'b1;
          res_d  = arg_ok ? RES_W'(arg_st) : '1;
        end
        OP_COUNT: begin
          resv_d = 1'b1;
          res_d  = RES_W'(q_count);
        end
        default: ;
      endcase
    end
  end

  assign tbl_en = pool_clr || (op != OP_NOP) || (idle_q && !q_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) st_q[i] <= (i == 0) ? ST_RUN : ST_FREE;
      run_q  <= '0;
      idle_q <= 1'b0;
    end else if (tbl_en) begin
      st_q   <= st_d;
      run_q  <= run_d;
      idle_q <= idle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= 1'b0;
      res_q  <= '0;
    end else begin
      resv_q <= resv_d;
      res_q  <= res_d;
    end
  end

  assign run_id    = run_q;
  assign idle      = idle_q;
  assign res_valid = resv_q;
  assign res_data  = res_q;

  // R1: whenever the core is owned, the table agrees with the owner
  a_r1_owner_running: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_q |-> (st_q[run_q] == ST_RUN));
  a_r3_full_keeps_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NEW && !free_found && !pool_clr && !idle_q) |=> $stable(q_count));
  a_r4_lone_yield: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && op == OP_YIELD && q_empty && !pool_clr) |=> (!idle_q && $stable(run_q)));
  a_r5_halt_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && op == OP_HALT && q_empty && !pool_clr) |=> idle_q);
  a_r9_wake_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !q_empty && !pool_clr) |=> !idle_q);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pool_clr |=> (idle_q && q_empty));
  a_r2_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP || pool_clr) |=> !resv_q);
endmodule

// File: tb/tb_ctx_sched.sv
module tb_ctx_sched;
  localparam int NSL   = 6;
  localparam int RES_W = 8;
  localparam int ID_W  = $clog2(NSL);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       cmd;
  logic [RES_W-1:0] cmd_arg;
  logic             pool_clr;
  logic [ID_W-1:0]  run_id;
  logic             idle;
  logic             res_valid;
  logic [RES_W-1:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int mst [NSL];
  int mq  [$];
  int mrun;
  bit midle;
  bit exp_rv;
  int exp_rd;

  always #4ns clk = ~clk;

  ctx_sched #(.NUM_SLOTS(NSL), .RES_W(RES_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_arg(cmd_arg), .pool_clr(pool_clr),
    .run_id(run_id), .idle(idle), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NSL; i++) mst[i] = (i == 0) ? 1 : 0;
    mq.delete();
    mrun  = 0;
    midle = 1'b0;
  endtask

  task automatic model_step(input int op, input int arg, input bit clr);
    int h;
    int f;
    exp_rv = 1'b0;
    exp_rd = 0;
    if (clr) begin
      for (int i = 0; i < NSL; i++) mst[i] = 0;
      mq.delete();
      midle = 1'b1;
      return;
    end
    f = -1;
    for (int i = NSL - 1; i >= 0; i--) if (mst[i] == 0) f = i;
    if (op == 6) begin exp_rv = 1'b1; exp_rd = (arg < NSL) ? mst[arg] : 255; end
    if (op == 7) begin exp_rv = 1'b1; exp_rd = mq.size(); end
    if (op == 4) begin exp_rv = 1'b1; exp_rd = (f >= 0) ? f : 255; end
    if (!midle) begin
      if (op == 1 && mq.size() > 0) begin
        h = mq.pop_front();
        mq.push_back(mrun);
        mst[mrun] = 2; mst[h] = 1; mrun = h;
      end else if (op == 2 || op == 3) begin
        mst[mrun] = (op == 2) ? 3 : 0;
        if (mq.size() > 0) begin
          h = mq.pop_front(); mst[h] = 1; mrun = h;
        end else midle = 1'b1;
      end
    end else if (mq.size() > 0) begin
      h = mq.pop_front(); mst[h] = 1; mrun = h; midle = 1'b0;
    end
    if (op == 4 && f >= 0) begin mst[f] = 2; mq.push_back(f); end
    if (op == 5 && arg < NSL) begin
      if (mst[arg] == 3) begin mst[arg] = 2; mq.push_back(arg); end
    end
  endtask

  // Called at a falling edge; compares outputs one edge later.
  task automatic step(input int op, input int arg, input bit clr, input string tag);
    cmd = 3'(op); cmd_arg = RES_W'(arg); pool_clr = clr;
    model_step(op, arg, clr);
    @(posedge clk);
    @(negedge clk);
    check(idle == midle, {tag, " idle"}, int'(idle), int'(midle));
    if (!midle) check(int'(run_id) == mrun, {tag, " run_id"}, int'(run_id), mrun);
    check(res_valid == exp_rv, {tag, " res_valid"}, int'(res_valid), int'(exp_rv));
    if (exp_rv) check(int'(res_data) == exp_rd, {tag, " res_data"}, int'(res_data), exp_rd);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd = '0; cmd_arg = '0; pool_clr = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(idle == 1'b0, "R1 idle", int'(idle), 0);
    check(run_id == '0, "R1 run_id", int'(run_id), 0);
    check(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    step(6, 0, 0, "R2 state of slot 0");
    step(6, 3, 0, "R2 state of free slot");
    step(6, 200, 0, "R2 out-of-range query");
    step(7, 0, 0, "R8 empty count");
    step(4, 0, 0, "R3 new first");
    step(4, 0, 0, "R3 new second");
    step(4, 0, 0, "R3 new third");
    step(4, 0, 0, "R3 new fourth");
    step(4, 0, 0, "R3 new fifth");
    step(4, 0, 0, "R3 new exhausted");
    step(7, 0, 0, "R8 full count");
    step(1, 0, 0, "R4 R11 yield");
    step(1, 0, 0, "R11 yield order");
    step(2, 0, 0, "R5 halt");
    step(6, 2, 0, "R2 halted code");
    step(5, 4, 0, "R7 resume ready no effect");
    step(5, 7, 0, "R7 resume out of range");
    step(7, 0, 0, "R7 count unchanged");
    step(5, 2, 0, "R7 resume halted");
    step(7, 0, 0, "R8 count after resume");
    for (int i = 0; i < 6; i++) step(3, 0, 0, "R6 free");
    step(1, 0, 0, "R9 yield while idle");
    step(2, 0, 0, "R9 halt while idle");
    step(4, 0, 0, "R9 new while idle");
    step(0, 0, 0, "R9 dispatch from idle");
    step(1, 0, 0, "R4 lone yield");
    step(4, 0, 1, "R10 clear over new");
    step(6, 0, 0, "R10 slot freed");
    step(7, 0, 0, "R10 queue empty");
    for (int n = 0; n < 4000; n++) begin
      int op;
      int arg;
      bit clr;
      op  = int'($urandom_range(0, 7));
      arg = int'($urandom_range(0, 9));
      clr = ($urandom_range(0, 199) == 0);
      step(op, arg, clr, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule